// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block holds the coherence state and tag of every line of one small direct-mapped private cache on a shared snooping bus. Each line is Invalid, Shared, Exclusive or Modified. Processor reads and writes arrive on one side. Snooped bus traffic arrives on the other side: a bus read, a bus write or an invalidate. The controller works out the next state of the addressed line. It issues the bus transaction that the request needs, drives the shared line when it holds the snooped tag, and raises a flush when its modified copy has to be written back for another cache.

Coherence uses write-invalidate. On a read miss, the new line becomes Exclusive or Shared depending on the shared signal that the other caches drive in the same cycle. All outputs are combinational in the request cycle. The line state changes at the next rising clock edge. An address splits into a low index field, which selects the line, and a high tag field, which is compared with the stored tag. The data arrays and bus arbitration live outside this block.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid and `bus_valid`, `shared_out`, `flush`, `evict_wb` and `cpu_stall` are low. State codes on `cpu_state`: Invalid=2'b00, Shared=2'b01, Exclusive=2'b10, Modified=2'b11.
- R2: A processor read that misses (the tag differs or the line is Invalid) issues a bus read in the same cycle (`bus_valid`=1, `bus_wr`=0, `bus_addr`=`cpu_addr`). The line takes the new tag and becomes Exclusive if `shared_in` is low, or Shared if it is high.
- R3: A processor read that hits in Modified, Exclusive or Shared leaves the state unchanged and issues no bus transaction.
- R4: A processor write that hits in Modified changes nothing and issues no bus transaction. A write hit in Exclusive moves the line to Modified with no bus transaction.
- R5: A processor write that hits in Shared, or that misses, moves the line to Modified with the new tag and issues an invalidating bus write (`bus_valid`=1, `bus_wr`=1).
- R6: A processor miss whose victim line is Modified under a different tag raises `evict_wb` in the same cycle, with `evict_addr` set to the victim's tag joined to the index.
- R7: A snooped bus read (`snp_op`=2'b00) that hits a valid line raises `shared_out` and leaves the line Shared. `flush` goes high only when the line was Modified.
- R8: A snooped bus write (`snp_op`=2'b01) that hits a valid line makes it Invalid and raises `shared_out`, with `flush` high only when the line was Modified. An invalidate (`snp_op`=2'b10) that hits makes the line Invalid without `flush`.
- R9: A snoop that misses (tag mismatch or Invalid line), and any snoop with the reserved code `snp_op`=2'b11, leaves all lines unchanged and keeps `shared_out` and `flush` low.
- R10: When `cpu_req` and `snp_valid` are high in the same cycle, only the snoop is processed. `cpu_stall` is high, and the processor request changes no state and issues no bus transaction or eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | Processor request is a write |
| cpu_addr | input | ADDR_W | Processor address (tag above index) |
| snp_valid | input | 1 | Snooped bus transaction valid |
| snp_op | input | 2 | Snoop kind: 00 read, 01 write, 10 invalidate, 11 reserved |
| snp_addr | input | ADDR_W | Snooped address |
| shared_in | input | 1 | Another cache holds the line being read |
| cpu_state | output | 2 | State of the line at `cpu_addr` (Invalid on tag mismatch) |
| cpu_stall | output | 1 | Processor request dropped because a snoop took the cycle |
| bus_valid | output | 1 | Bus transaction issued this cycle |
| bus_wr | output | 1 | Issued transaction is an invalidating write (else a read) |
| bus_addr | output | ADDR_W | Address of the issued transaction |
| shared_out | output | 1 | This cache holds the snooped tag in a valid state |
| flush | output | 1 | Modified data must be written back for the snoop |
| evict_wb | output | 1 | Modified victim must be written back before the fill |
| evict_addr | output | ADDR_W | Address of the victim line |

## Verification
The bench drives every index from each of the four states and applies each processor and snoop kind. This covers the corner cases: a write in Exclusive, a write in Shared, a snoop under a foreign tag, the reserved snoop code, a replacement of a Modified victim, and a snoop that collides with a processor request. A design that broadcasts on the Exclusive-to-Modified upgrade would show a stray `bus_valid`. One that ignores the tag on snoops would invalidate or flush lines it does not hold. One that lets the processor act during a snoop would issue bus traffic or end in Modified instead of Invalid. Dropping the victim write-back or flushing on a plain invalidate shows up directly on `evict_wb` and `flush`.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } mesi_t;

    typedef enum logic [1:0] {
        SNP_RD  = 2'b00,
        SNP_WR  = 2'b01,
        SNP_INV = 2'b10,
        SNP_NOP = 2'b11
    } snp_op_t;

endpackage

// File: rtl/mesi_cpu_step.sv
module mesi_cpu_step
    import mesi_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             req,
    input  logic             we,
    input  logic [TAG_W-1:0] tag,
    input  logic             shared_in,
    input  logic [TAG_W-1:0] line_tag,
    input  mesi_t            line_st,
    output logic [TAG_W-1:0] nxt_tag,
    output mesi_t            nxt_st,
    output logic             bus_valid,
    output logic             bus_wr,
    output logic             evict
);
    logic hit;

    always_comb begin
        hit       = (line_tag == tag) && (line_st != ST_I);
        nxt_tag   = line_tag;
        nxt_st    = line_st;
        bus_valid = 1'b0;
        bus_wr    = 1'b0;
        evict     = 1'b0;
        if (req) begin
            evict = !hit && (line_st == ST_M);
            if (!we) begin
                if (!hit) begin
                    nxt_tag   = tag;
                    nxt_st    = shared_in ? ST_S : ST_E;
                    bus_valid = 1'b1;
                end
            end else begin
                nxt_tag = tag;
                nxt_st  = ST_M;
                if (!hit || line_st == ST_S) begin
                    bus_valid = 1'b1;
                    bus_wr    = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mesi_snoop_step.sv
module mesi_snoop_step
    import mesi_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             valid,
    input  snp_op_t          op,
    input  logic [TAG_W-1:0] tag,
    input  logic [TAG_W-1:0] line_tag,
    input  mesi_t            line_st,
    output mesi_t            nxt_st,
    output logic             hit,
    output logic             flush
);
    always_comb begin
        hit    = valid && (op != SNP_NOP) && (line_tag == tag) && (line_st != ST_I);
        nxt_st = line_st;
        flush  = 1'b0;
        if (hit) begin
            case (op)
                SNP_RD: begin
                    nxt_st = ST_S;
                    flush  = (line_st == ST_M);
                end
                SNP_WR: begin
                    nxt_st = ST_I;
                    flush  = (line_st == ST_M);
                end
                SNP_INV: nxt_st = ST_I;
                default: nxt_st = line_st;
            endcase
        end
    end

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int LINES = 4,
    parameter int TAG_W = 4,
    localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              shared_in,
    output logic [1:0]        cpu_state,
    output logic              cpu_stall,
    output logic              bus_valid,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              shared_out,
    output logic              flush,
    output logic              evict_wb,
    output logic [ADDR_W-1:0] evict_addr
);
    typedef struct packed {
        logic [TAG_W-1:0] tag;
        mesi_t            st;
    } line_t;

    typedef struct packed {
        line_t [LINES-1:0] lines;
    } regs_t;

    regs_t state_d, state_q;

    logic [IDX_W-1:0] cpu_idx, snp_idx;
    logic [TAG_W-1:0] cpu_tag, snp_tag;
    line_t            cpu_line, snp_line;
    logic             cpu_go;

    logic [TAG_W-1:0] c_nxt_tag;
    mesi_t            c_nxt_st;
    logic             c_bus_valid, c_bus_wr, c_evict;
    mesi_t            s_nxt_st;
    logic             s_hit, s_flush;

    assign cpu_idx  = cpu_addr[IDX_W-1:0];
    assign cpu_tag  = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx  = snp_addr[IDX_W-1:0];
    assign snp_tag  = snp_addr[ADDR_W-1:IDX_W];
    assign cpu_line = state_q.lines[cpu_idx];
    assign snp_line = state_q.lines[snp_idx];
    assign cpu_go   = cpu_req && !snp_valid;

    mesi_cpu_step #(.TAG_W(TAG_W)) u_cpu (
        .req       (cpu_go),
        .we        (cpu_we),
        .tag       (cpu_tag),
        .shared_in (shared_in),
        .line_tag  (cpu_line.tag),
        .line_st   (cpu_line.st),
        .nxt_tag   (c_nxt_tag),
        .nxt_st    (c_nxt_st),
        .bus_valid (c_bus_valid),
        .bus_wr    (c_bus_wr),
        .evict     (c_evict)
    );

    mesi_snoop_step #(.TAG_W(TAG_W)) u_snp (
        .valid    (snp_valid),
        .op       (snp_op_t'(snp_op)),
        .tag      (snp_tag),
        .line_tag (snp_line.tag),
        .line_st  (snp_line.st),
        .nxt_st   (s_nxt_st),
        .hit      (s_hit),
        .flush    (s_flush)
    );

    always_comb begin
        state_d = state_q;
        if (s_hit) begin
            state_d.lines[snp_idx].st = s_nxt_st;
        end
        if (cpu_go) begin
            state_d.lines[cpu_idx].tag = c_nxt_tag;
            state_d.lines[cpu_idx].st  = c_nxt_st;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cpu_state  = (cpu_line.tag == cpu_tag) ? cpu_line.st : ST_I;
    assign cpu_stall  = cpu_req && snp_valid;
    assign bus_valid  = c_bus_valid;
    assign bus_wr     = c_bus_wr;
    assign bus_addr   = cpu_addr;
    assign shared_out = s_hit;
    assign flush      = s_flush;
    assign evict_wb   = c_evict;
    assign evict_addr = {cpu_line.tag, cpu_idx};

    // Snoop owns the cycle: no processor side effects (R10)
    assert_snoop_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> (!bus_valid && !evict_wb));

    assert_snoop_wins_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && snp_valid && cpu_we && !shared_out) |=> $stable(state_q));

    // A flush only accompanies a valid snoop hit (R7, R8)
    assert_flush_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> shared_out);

    // Read hits stay quiet on the bus (R3)
    assert_read_hit_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_go && !cpu_we && cpu_state != ST_I) |-> !bus_valid);

    // Exclusive upgrade is silent and lands in Modified (R4)
    assert_silent_upgrade_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_go && cpu_we && cpu_state == ST_E) |-> !bus_valid);

    assert_upgrade_lands_m_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_go && cpu_we && cpu_state == ST_E) |=> state_q.lines[$past(cpu_idx)].st == ST_M);

    // Any accepted write leaves the line Modified under the written tag (R5)
    assert_write_to_m_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_go && cpu_we) |=> (state_q.lines[$past(cpu_idx)].st == ST_M &&
                                state_q.lines[$past(cpu_idx)].tag == $past(cpu_tag)));

    // A missing snoop with no processor activity leaves all lines as they were (R9)
    assert_snoop_miss_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !shared_out) |=> $stable(state_q));

endmodule

// File: tb/mesi_snoop_ctrl_test.sv
module mesi_snoop_ctrl_test;
    localparam int LINES  = 4;
    localparam int TAG_W  = 4;
    localparam int IDX_W  = 2;
    localparam int ADDR_W = TAG_W + IDX_W;

    localparam logic [1:0] SI = 2'b00, SS = 2'b01, SE = 2'b10, SM = 2'b11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              snp_valid = 1'b0;
    logic [1:0]        snp_op = 2'b00;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              shared_in = 1'b0;
    logic [1:0]        cpu_state;
    logic              cpu_stall, bus_valid, bus_wr, shared_out, flush, evict_wb;
    logic [ADDR_W-1:0] bus_addr, evict_addr;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mesi_snoop_ctrl #(.LINES(LINES), .TAG_W(TAG_W)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr), .shared_in(shared_in),
        .cpu_state(cpu_state), .cpu_stall(cpu_stall), .bus_valid(bus_valid), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .shared_out(shared_out), .flush(flush), .evict_wb(evict_wb),
        .evict_addr(evict_addr)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        cpu_req = 1'b0; cpu_we = 1'b0; snp_valid = 1'b0; snp_op = 2'b00; shared_in = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic probe(input logic [ADDR_W-1:0] a, input string req, input logic [1:0] exp);
        @(negedge clk);
        idle();
        cpu_addr = a;
        #1;
        chk(req, "cpu_state", cpu_state, exp);
    endtask

    task automatic cpu_access(input logic [ADDR_W-1:0] a, input logic we, input logic sh);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; shared_in = sh;
        @(negedge clk);
        idle();
    endtask

    // Op codes for the sweep
    // 0 read shared_in low, 1 read shared_in high, 2 write, 3 snoop read, 4 snoop write,
    // 5 snoop invalidate, 6 reserved snoop, 7 snoop read other tag, 8 read other tag, 9 collision
    function automatic string req_of(input int op);
        case (op)
            0, 1: return "R2/R3";
            2:    return "R4/R5";
            3:    return "R7";
            4, 5: return "R8";
            6, 7: return "R9";
            8:    return "R6";
            default: return "R10";
        endcase
    endfunction

    initial begin : main
        logic [ADDR_W-1:0] a, o;
        logic [1:0] nst;
        logic [5:0] exp_out, act_out;
        logic bv, bw, sh, fl, ev, st;

        do_reset();
        #1;
        chk("R1", "outputs after reset",
            {bus_valid, shared_out, flush, evict_wb, cpu_stall}, 0);
        for (int i = 0; i < LINES; i++) begin
            probe(ADDR_W'((i + 3) * LINES + i), "R1", SI);
        end

        for (int idx = 0; idx < LINES; idx++) begin
            for (int s = 0; s < 4; s++) begin
                for (int op = 0; op < 10; op++) begin
                    a = ADDR_W'(((idx + 3) % (1 << TAG_W)) * LINES + idx);
                    o = a ^ ADDR_W'(LINES);
                    do_reset();
                    case (s)
                        1: cpu_access(a, 1'b0, 1'b1);
                        2: cpu_access(a, 1'b0, 1'b0);
                        3: cpu_access(a, 1'b1, 1'b0);
                        default: ;
                    endcase

                    // expected response, derived from the requirements
                    nst = 2'(s); bv = 0; bw = 0; sh = 0; fl = 0; ev = 0; st = 0;
                    case (op)
                        0: if (s == 0) begin nst = SE; bv = 1; end
                        1: if (s == 0) begin nst = SS; bv = 1; end
                        2: begin nst = SM; if (s == 0 || s == 1) begin bv = 1; bw = 1; end end
                        3: if (s != 0) begin nst = SS; sh = 1; fl = (s == 3); end
                        4: if (s != 0) begin nst = SI; sh = 1; fl = (s == 3); end
                        5: if (s != 0) begin nst = SI; sh = 1; end
                        8: begin nst = SI; bv = 1; ev = (s == 3); end
                        9: begin st = 1; if (s != 0) begin nst = SI; sh = 1; fl = (s == 3); end end
                        default: ;
                    endcase

                    @(negedge clk);
                    case (op)
                        0, 1, 2: begin cpu_req = 1; cpu_we = (op == 2); cpu_addr = a; shared_in = (op == 1); end
                        3, 4, 5, 6: begin snp_valid = 1; snp_op = 2'(op - 3); snp_addr = a; end
                        7: begin snp_valid = 1; snp_op = 2'b00; snp_addr = o; end
                        8: begin cpu_req = 1; cpu_we = 0; cpu_addr = o; shared_in = 0; end
                        default: begin
                            cpu_req = 1; cpu_we = 1; cpu_addr = a;
                            snp_valid = 1; snp_op = 2'b01; snp_addr = a;
                        end
                    endcase
                    #1;
                    exp_out = {bv, bw, sh, fl, ev, st};
                    act_out = {bus_valid, bus_wr, shared_out, flush, evict_wb, cpu_stall};
                    chk(req_of(op), "outputs {bus_valid,bus_wr,shared_out,flush,evict_wb,cpu_stall}",
                        act_out, exp_out);
                    if (bv) chk(req_of(op), "bus_addr", bus_addr, (op == 8) ? o : a);
                    if (ev) chk("R6", "evict_addr", evict_addr, a);

                    probe(a, req_of(op), nst);
                    if (op == 8) probe(o, "R2", SE);
                    probe(ADDR_W'(((idx + 1) % LINES)), req_of(op), SI);
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule